// File: doc/BRIEF.md
# Program Suspend Controller

This block sits between the host write/read port and a program engine that writes one word, or a whole buffer of words, into the array. A host can ask for a running program to stop so that it can read the array. The request does not stop the engine at once. It is held pending until the engine reaches its next step boundary, which is the only place where the engine can stop cleanly. The engine is then frozen at that boundary until the host sends a resume command. While the program is paused, the host may only read. Every other write cycle is discarded.

The status byte is driven on every cycle. Bit 7 means ready and bit 2 means program suspended. Both bits set together means the program is suspended. A separate input says that an erase is already suspended elsewhere in the device. That flag is shown on status bit 6, and a program started under it can be suspended in the same way. A small stub engine is built into the block for testing. It runs a fixed number of steps per program kind and marks each step boundary with a single-cycle safe-point strobe.

Top module: `pgm_pause_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, engine_pause is low, eng_step is 0 and no read is granted.
- R2: Command byte 0x40 starts a word program of WORD_STEPS steps, and 0xE8 starts a buffer program of BUF_STEPS steps. Each step lasts STEP_CYC cycles. Bit 7 clears on the clock that takes the command and sets again exactly steps*STEP_CYC clocks later. eng_step then equals the step count.
- R3: Suspend command byte 0xB0 is accepted whatever value host_addr carries.
- R4: A suspend taken during step k pauses the engine at the boundary that ends step k. engine_pause rises only in the cycle after a safe-point strobe, and eng_step at that point is k+1.
- R5: While a program runs, or while a suspend is still pending, the status byte keeps being driven with bits 7 and 2 both clear.
- R6: While suspended, status bits 7 and 2 are both set, engine_pause is high and eng_step holds its value.
- R7: A read request is granted, with host_addr passed to array_rd_addr, only while bit 7 is set (idle or suspended). During a running program it is refused and array_rd_addr is 0.
- R8: While suspended, any write cycle other than resume byte 0xD0 is ignored. The status byte and eng_step do not change, and the remaining run time is unaffected.
- R9: Resume clears bits 7 and 2 on the next clock. The engine continues from the boundary where it stopped, so (steps - stopped_step)*STEP_CYC clocks remain.
- R10: A suspend command while no program is running has no effect. The status stays 0x80.
- R11: Status bit 6 follows erase_susp. A program started while that flag is high suspends and resumes exactly as in R4, R6 and R9, with bit 6 still shown.
- R12: A suspend requested during the final step is dropped. The program completes on time and bit 2 never sets.
- R13: While a program runs, write cycles other than 0xB0 are ignored and do not change the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write cycle strobe |
| wr_cmd | input | CMD_W | Command byte of the write cycle |
| host_addr | input | ADDR_W | Host address for both writes and reads |
| rd_req | input | 1 | Host read request |
| erase_susp | input | 1 | An erase is currently suspended |
| engine_pause | output | 1 | Hold request to the program engine |
| eng_step | output | STEP_W | Number of engine steps completed |
| sr | output | SR_W | Status byte: bit 7 ready, bit 6 erase suspended, bit 2 program suspended |
| rd_grant | output | 1 | Read request accepted |
| array_rd_addr | output | ADDR_W | Address presented to the array for a granted read |

## Verification
The checker watches the rules that hold on every cycle. It checks that the pause begins only right after a safe-point strobe and that both status bits are set whenever the engine is held. It also checks that the step count stays frozen while paused, that reads are never granted while busy, and the one-cycle effects of suspend, resume and ignored writes. Other behaviour can only be shown by the bench's scenarios. These are the step at which a suspend lands for each issue cycle, the exact completion times before and after a pause, the dropping of a suspend during the last step, and nesting under a suspended erase. To cover them, the bench sweeps every issue cycle of both program kinds, with the erase flag low and high.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_RUN  = 2'd1,
      PS_PEND = 2'd2,
      PS_SUSP = 2'd3
   } pps_state_e;

   localparam int SR_READY_BIT = 7;
   localparam int SR_ESUSP_BIT = 6;
   localparam int SR_PSUSP_BIT = 2;
endpackage

// File: rtl/pps_cmd_dec.sv
module pps_cmd_dec #(
   parameter int             CMD_W    = 8,
   parameter logic [CMD_W-1:0] CODE_WORD = 8'h40,
   parameter logic [CMD_W-1:0] CODE_BUF  = 8'hE8,
   parameter logic [CMD_W-1:0] CODE_SUSP = 8'hB0,
   parameter logic [CMD_W-1:0] CODE_RES  = 8'hD0
) (
   input  logic             wr_valid,
   input  logic [CMD_W-1:0] wr_cmd,
   output logic             hit_word,
   output logic             hit_buf,
   output logic             hit_susp,
   output logic             hit_res
);
   // address plays no part in decoding: commands land from any location
   always_comb begin
      hit_word = wr_valid && (wr_cmd == CODE_WORD);
      hit_buf  = wr_valid && (wr_cmd == CODE_BUF);
      hit_susp = wr_valid && (wr_cmd == CODE_SUSP);
      hit_res  = wr_valid && (wr_cmd == CODE_RES);
   end
endmodule

// File: rtl/pps_stub_engine.sv
module pps_stub_engine #(
   parameter int WORD_STEPS = 2,
   parameter int BUF_STEPS  = 8,
   parameter int STEP_CYC   = 4,
   parameter int STEP_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              use_buf,
   input  logic              pause,
   output logic              busy,
   output logic              safe_pt,
   output logic              done,
   output logic [STEP_W-1:0] step
);
   localparam int CYC_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

   logic [STEP_W-1:0] len_q;
   logic              step_end;
   logic              last_step;

   generate
      if (STEP_CYC == 1) begin : g_single
         assign step_end = busy && !pause;
      end else begin : g_multi
         logic [CYC_W-1:0] cyc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cyc_q <= '0;
            end else if (start && !busy) begin
               cyc_q <= '0;
            end else if (busy && !pause) begin
               if (cyc_q == CYC_W'(STEP_CYC - 1)) cyc_q <= '0;
               else                               cyc_q <= cyc_q + 1'b1;
            end
         end
         assign step_end = busy && !pause && (cyc_q == CYC_W'(STEP_CYC - 1));
      end
   endgenerate

   assign last_step = (step == len_q - STEP_W'(1));
   assign safe_pt   = step_end && !last_step;
   assign done      = step_end && last_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         step  <= '0;
         len_q <= STEP_W'(WORD_STEPS);
      end else if (start && !busy) begin
         busy  <= 1'b1;
         step  <= '0;
         len_q <= use_buf ? STEP_W'(BUF_STEPS) : STEP_W'(WORD_STEPS);
      end else if (step_end) begin
         step <= step + 1'b1;
         if (last_step) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit_word,
   input  logic       hit_buf,
   input  logic       hit_susp,
   input  logic       hit_res,
   input  logic       eng_safe,
   input  logic       eng_done,
   output pps_state_e state,
   output logic       eng_start,
   output logic       eng_use_buf
);
   pps_state_e nxt;

   assign eng_start   = (state == PS_IDLE) && (hit_word || hit_buf);
   assign eng_use_buf = hit_buf;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_IDLE: if (eng_start) nxt = PS_RUN;
         PS_RUN: begin
            if (eng_done)                  nxt = PS_IDLE;
            else if (hit_susp && eng_safe) nxt = PS_SUSP;
            else if (hit_susp)             nxt = PS_PEND;
         end
         PS_PEND: begin
            if (eng_done)      nxt = PS_IDLE;
            else if (eng_safe) nxt = PS_SUSP;
         end
         PS_SUSP: if (hit_res) nxt = PS_RUN;
         default: nxt = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pps_status.sv
module pps_status
   import pps_pkg::*;
#(
   parameter int SR_W   = 8,
   parameter int ADDR_W = 16
) (
   input  pps_state_e        state,
   input  logic              erase_susp,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [SR_W-1:0]   sr,
   output logic              rd_grant,
   output logic [ADDR_W-1:0] array_rd_addr
);
   logic ready;
   logic psusp;

   assign ready = (state == PS_IDLE) || (state == PS_SUSP);
   assign psusp = (state == PS_SUSP);

   generate
      for (genvar i = 0; i < SR_W; i++) begin : g_bit
         if (i == SR_READY_BIT) begin : g_rdy
            assign sr[i] = ready;
         end else if (i == SR_ESUSP_BIT) begin : g_es
            assign sr[i] = erase_susp;
         end else if (i == SR_PSUSP_BIT) begin : g_ps
            assign sr[i] = psusp;
         end else begin : g_zero
            assign sr[i] = 1'b0;
         end
      end
   endgenerate

   assign rd_grant      = rd_req && ready;
   assign array_rd_addr = rd_grant ? host_addr : '0;
endmodule

// File: rtl/pgm_pause_ctrl.sv
module pgm_pause_ctrl
   import pps_pkg::*;
#(
   parameter int CMD_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int SR_W       = 8,
   parameter int WORD_STEPS = 2,
   parameter int BUF_STEPS  = 8,
   parameter int STEP_CYC   = 4,
   parameter int STEP_W     = $clog2(BUF_STEPS + 1),
   parameter logic [CMD_W-1:0] CMD_WORD    = 8'h40,
   parameter logic [CMD_W-1:0] CMD_BUF     = 8'hE8,
   parameter logic [CMD_W-1:0] CMD_SUSPEND = 8'hB0,
   parameter logic [CMD_W-1:0] CMD_RESUME  = 8'hD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [CMD_W-1:0]  wr_cmd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              rd_req,
   input  logic              erase_susp,
   output logic              engine_pause,
   output logic [STEP_W-1:0] eng_step,
   output logic [SR_W-1:0]   sr,
   output logic              rd_grant,
   output logic [ADDR_W-1:0] array_rd_addr
);
   generate
      if (WORD_STEPS < 1)          begin : g_bad_word $error("WORD_STEPS must be at least 1"); end
      if (BUF_STEPS < WORD_STEPS)  begin : g_bad_buf  $error("BUF_STEPS must not be below WORD_STEPS"); end
      if (STEP_CYC < 1)            begin : g_bad_cyc  $error("STEP_CYC must be at least 1"); end
      if (SR_W < 8)                begin : g_bad_sr   $error("SR_W must hold bits 0 to 7"); end
      if ((1 << STEP_W) <= BUF_STEPS) begin : g_bad_sw $error("STEP_W too narrow for BUF_STEPS"); end
   endgenerate

   logic       hit_word, hit_buf, hit_susp, hit_res;
   logic       eng_start, eng_use_buf;
   logic       eng_busy, eng_safe, eng_done;
   pps_state_e state;

   pps_cmd_dec #(
      .CMD_W(CMD_W), .CODE_WORD(CMD_WORD), .CODE_BUF(CMD_BUF),
      .CODE_SUSP(CMD_SUSPEND), .CODE_RES(CMD_RESUME)
   ) u_dec (
      .wr_valid(wr_valid), .wr_cmd(wr_cmd),
      .hit_word(hit_word), .hit_buf(hit_buf),
      .hit_susp(hit_susp), .hit_res(hit_res)
   );

   pps_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .hit_word(hit_word), .hit_buf(hit_buf),
      .hit_susp(hit_susp), .hit_res(hit_res),
      .eng_safe(eng_safe), .eng_done(eng_done),
      .state(state), .eng_start(eng_start), .eng_use_buf(eng_use_buf)
   );

   assign engine_pause = (state == PS_SUSP);

   pps_stub_engine #(
      .WORD_STEPS(WORD_STEPS), .BUF_STEPS(BUF_STEPS),
      .STEP_CYC(STEP_CYC), .STEP_W(STEP_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(eng_start), .use_buf(eng_use_buf), .pause(engine_pause),
      .busy(eng_busy), .safe_pt(eng_safe), .done(eng_done), .step(eng_step)
   );

   pps_status #(.SR_W(SR_W), .ADDR_W(ADDR_W)) u_stat (
      .state(state), .erase_susp(erase_susp),
      .rd_req(rd_req), .host_addr(host_addr),
      .sr(sr), .rd_grant(rd_grant), .array_rd_addr(array_rd_addr)
   );
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
   parameter int             CMD_W     = 8,
   parameter int             SR_W      = 8,
   parameter int             STEP_W    = 4,
   parameter logic [CMD_W-1:0] SUSP_CODE = 8'hB0,
   parameter logic [CMD_W-1:0] RES_CODE  = 8'hD0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [CMD_W-1:0]  wr_cmd,
   input logic              rd_grant,
   input logic [SR_W-1:0]   sr,
   input logic              engine_pause,
   input logic [STEP_W-1:0] eng_step,
   input logic              eng_safe,
   input logic              eng_busy
);
   // R4
   pause_at_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(engine_pause) |-> $past(eng_safe));

   // R6
   susp_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      engine_pause |-> (sr[7] && sr[2]));

   // R6
   step_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_pause && $past(engine_pause)) |-> $stable(eng_step));

   // R5
   busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !engine_pause) |-> (!sr[7] && !sr[2]));

   // R7
   read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant |-> sr[7]);

   // R9
   resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr[2] && wr_valid && wr_cmd == RES_CODE) |=> (!sr[7] && !sr[2]));

   // R8
   ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr[2] && wr_valid && wr_cmd != RES_CODE) |=> (sr[2] && $stable(eng_step)));

   // R10
   idle_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr[7] && !sr[2] && wr_valid && wr_cmd == SUSP_CODE) |=> (sr[7] && !sr[2]));
endmodule

bind pgm_pause_ctrl pps_chk #(
   .CMD_W(CMD_W), .SR_W(SR_W), .STEP_W(STEP_W),
   .SUSP_CODE(CMD_SUSPEND), .RES_CODE(CMD_RESUME)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
   .rd_grant(rd_grant), .sr(sr), .engine_pause(engine_pause),
   .eng_step(eng_step), .eng_safe(eng_safe), .eng_busy(eng_busy)
);

// File: tb/pgm_pause_ctrl_tb.sv
module pgm_pause_ctrl_tb;
   localparam int WS = 2;
   localparam int BS = 8;
   localparam int SC = 4;
   localparam int SW = $clog2(BS + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [7:0]    wr_cmd = 8'h00;
   logic [15:0]   host_addr = 16'h0000;
   logic          rd_req = 1'b0;
   logic          erase_susp = 1'b0;
   logic          engine_pause;
   logic [SW-1:0] eng_step;
   logic [7:0]    sr;
   logic          rd_grant;
   logic [15:0]   array_rd_addr;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   pgm_pause_ctrl #(.WORD_STEPS(WS), .BUF_STEPS(BS), .STEP_CYC(SC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
      .host_addr(host_addr), .rd_req(rd_req), .erase_susp(erase_susp),
      .engine_pause(engine_pause), .eng_step(eng_step), .sr(sr),
      .rd_grant(rd_grant), .array_rd_addr(array_rd_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] c, input logic [15:0] a);
      wr_valid  = 1'b1;
      wr_cmd    = c;
      host_addr = a;
      @(negedge clk);
      wr_valid  = 1'b0;
   endtask

   task automatic probe_read(input logic [15:0] a, input bit exp_grant, input string req);
      rd_req    = 1'b1;
      host_addr = a;
      #1;
      chk(rd_grant == exp_grant, req, int'(rd_grant), int'(exp_grant));
      chk(array_rd_addr == (exp_grant ? a : 16'h0), req, int'(array_rd_addr),
          exp_grant ? int'(a) : 0);
      rd_req = 1'b0;
   endtask

   function automatic logic [7:0] es_bit(input bit es);
      return es ? 8'h40 : 8'h00;
   endfunction

   // counts cycles until ready returns, starting at a negedge
   task automatic wait_ready(output int n);
      n = 0;
      while (!sr[7] && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // R13: spurious writes during a run leave completion time unchanged
   task automatic plain_run(input bit use_buf);
      int steps = use_buf ? BS : WS;
      int t;
      wr(use_buf ? 8'hE8 : 8'h40, 16'h0010);
      chk(sr == 8'h00, "R2 busy status", sr, 8'h00);
      probe_read(16'h00AA, 1'b0, "R7 read refused while running");
      wr(8'hD0, 16'h0001);
      wr(8'h40, 16'h0002);
      t = 2;
      begin
         int n;
         wait_ready(n);
         t += n;
      end
      chk(t == steps * SC, "R2/R13 completion cycles", t, steps * SC);
      chk(sr == 8'h80, "R2 ready after program", sr, 8'h80);
      chk(eng_step == SW'(steps), "R2 final step count", int'(eng_step), steps);
      probe_read(16'h0BEE, 1'b1, "R7 read granted when idle");
   endtask

   task automatic sweep_case(input bit es, input bit use_buf, input int w);
      int steps = use_buf ? BS : WS;
      int t;
      int s;
      logic [7:0] exp_sr;
      erase_susp = es;
      wr(use_buf ? 8'hE8 : 8'h40, 16'h0000);
      t = 0;
      repeat (w) begin
         @(negedge clk);
         t++;
      end
      // R3: suspend accepted from a varying address
      wr(8'hB0, 16'(w * 37 + 5));
      t++;
      if (w / SC == steps - 1) begin
         // R12: suspend during final step is dropped
         while (!sr[7] && t < 1000) begin
            chk(sr[2] == 1'b0, "R12 no suspend on last step", sr, es_bit(es));
            @(negedge clk);
            t++;
         end
         chk(t == steps * SC, "R12 completion on time", t, steps * SC);
         chk(sr == (8'h80 | es_bit(es)), "R12 ready, not suspended", sr, 8'h80 | es_bit(es));
      end else begin
         s = w / SC + 1;
         while (!sr[2] && t < 1000) begin
            chk(sr == es_bit(es), "R5 pending status driven", sr, es_bit(es));
            @(negedge clk);
            t++;
         end
         chk(t == s * SC, "R4 suspension cycle", t, s * SC);
         chk(eng_step == SW'(s), "R4 step at suspension", int'(eng_step), s);
         exp_sr = 8'h84 | es_bit(es);
         chk(sr == exp_sr, "R6/R11 suspended status", sr, exp_sr);
         chk(engine_pause == 1'b1, "R6 pause high", int'(engine_pause), 1);
         probe_read(16'(w + 16'h0300), 1'b1, "R7 read granted while suspended");
         wr(8'h40, 16'h0007);
         wr(8'hE8, 16'h0008);
         wr(8'hB0, 16'h0009);
         wr(8'h70, 16'h000A);
         chk(sr == exp_sr, "R8 status unchanged by ignored writes", sr, exp_sr);
         chk(eng_step == SW'(s), "R8 step unchanged by ignored writes", int'(eng_step), s);
         wr(8'hD0, 16'hFFFF);
         chk(sr == es_bit(es), "R9 bits clear after resume", sr, es_bit(es));
         chk(eng_step == SW'(s), "R9 resume point", int'(eng_step), s);
         begin
            int n;
            wait_ready(n);
            chk(n == (steps - s) * SC, "R9 remaining cycles", n, (steps - s) * SC);
         end
         chk(eng_step == SW'(steps), "R9 all steps done", int'(eng_step), steps);
      end
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(sr == 8'h80, "R1 reset status", sr, 8'h80);
      chk(engine_pause == 1'b0, "R1 reset pause", int'(engine_pause), 0);
      chk(eng_step == '0, "R1 reset step", int'(eng_step), 0);
      chk(rd_grant == 1'b0, "R1 no grant without request", int'(rd_grant), 0);
      // R10
      wr(8'hB0, 16'h1234);
      chk(sr == 8'h80, "R10 idle suspend no effect", sr, 8'h80);
      @(negedge clk);
      chk(sr == 8'h80, "R10 still idle", sr, 8'h80);
      chk(engine_pause == 1'b0, "R10 no pause", int'(engine_pause), 0);
      plain_run(1'b0);
      plain_run(1'b1);
      // R11: erase flag shown on bit 6 while idle
      erase_susp = 1'b1;
      #1;
      chk(sr == 8'hC0, "R11 erase flag shown", sr, 8'hC0);
      for (int es = 0; es < 2; es++) begin
         for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < (b ? BS : WS) * SC; w++) begin
               sweep_case(es[0], b[0], w);
            end
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule